// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked internal client and an 8192 x 8 asynchronous static RAM. The client raises a single-cycle request carrying a 13-bit address, a direction flag and, for a store, one data byte. The block then drives the memory's address lines and its four control strobes with every timing minimum counted out in clock cycles. It reports completion with a one-clock ready pulse, and for a load it returns the byte it captured on that same clock.

The memory is selected through two enables of opposite sense: an active-low select and an active-high select. Reads use an active-low output enable and stores use an active-low write strobe. The bidirectional data pins are handled through three ports: the driven byte, a drive enable and the sampled byte. Parameters give the minimum cycle counts for the read cycle, the output-enable-to-data delay, the write pulse, the data setup before the strobe rises, and the total write cycle. The sequencer keeps the output enable high for the whole of a store and drives the bus only while the write strobe is low, plus one hold clock. This ordering means the two sides never fight over the data pins.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, with no request, the memory is deselected (`mem_cs1_n_o`=1, `mem_cs2_o`=0), `mem_oe_n_o`=1, `mem_we_n_o`=1, `mem_dq_oe_o`=0 and `rdy_o`=0.
- R2: A request is taken only when the sequencer is idle. A request raised while an access is in progress causes no memory write and no extra ready pulse.
- R3: A load (`wr_i`=0) selects the memory with `mem_oe_n_o`=0 and `mem_we_n_o`=1 for N_RD = max(RD_CYCLES, OE_WAIT) cycles. It captures `mem_dq_i` at the end of the last of those cycles. `rdy_o` rises N_RD+1 cycles after the accepting clock edge, and `rdata_o` holds the captured byte.
- R4: The capture point lies at least RD_CYCLES cycles after the address became stable with the memory selected, and at least OE_WAIT cycles after `mem_oe_n_o` fell.
- R5: A store (`wr_i`=1) runs one selected setup cycle with `mem_we_n_o`=1. It then holds `mem_we_n_o` low for N_WP = max(WE_PULSE, DATA_SETUP, WR_CYCLES-2) cycles, followed by one selected hold cycle. `rdy_o` rises N_WP+3 cycles after the accepting edge.
- R6: `mem_oe_n_o` stays high for the whole of a store. `mem_dq_oe_o` is high only while `mem_we_n_o` is low or on the single cycle after it rises, and is never high while `mem_oe_n_o` is low.
- R7: Address and store data are registered when the request is taken. `mem_addr_o` and `mem_dq_o` stay constant while the memory is selected, whatever `addr_i`, `wdata_i` and `wr_i` do.
- R8: `rdy_o` is high for exactly one clock per access.
- R9: `mem_cs1_n_o` is always the inverse of `mem_cs2_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled only when idle |
| wr_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Store data |
| rdy_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 8 | Load data, valid with rdy_o |
| mem_addr_o | output | 13 | Memory address lines |
| mem_cs1_n_o | output | 1 | Active-low chip select |
| mem_cs2_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_dq_o | output | 8 | Byte driven onto the data pins |
| mem_dq_oe_o | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 8 | Byte sampled from the data pins |

## Verification
The bench drives random mixes of loads and stores. Addresses cluster at both ends of the range so that recent stores are read back often, and full-range addresses are mixed in. Directed cases cover all-zero and all-one data, the first and last address, and a store followed at once by a load of the same byte. The bench memory model returns an inverted byte whenever the read timing is cut short, and it stores a corrupted byte whenever the strobe width, the data setup or the hold drive is short. A wrong capture cycle therefore shows up in the read-back value, while the measured ready latency separates load sequencing from store sequencing. A store request raised in the middle of a busy access, followed by a read of its target, shows whether busy-time requests are ignored. Scrambling the client inputs right after acceptance shows whether address and data were registered.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_DONE
  } asram_st_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned N_RD  = 3,
  parameter int unsigned N_WP  = 3,
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             accept_o,
  output logic             capture_o,
  output asram_st_e        state_d_o
);

  asram_st_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    len_o     = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (wr_i) begin
          state_d = ST_WSET;
        end else begin
          state_d = ST_RD;
          len_o   = CNT_W'(N_RD - 1);
        end
      end
      ST_RD: if (zero_i) begin
        capture_o = 1'b1;
        state_d   = ST_DONE;
      end
      ST_WSET: begin
        load_o  = 1'b1;
        len_o   = CNT_W'(N_WP - 1);
        state_d = ST_WPUL;
      end
      ST_WPUL: if (zero_i) state_d = ST_WHLD;
      ST_WHLD: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;

endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  asram_st_e state_d_i,
  output logic      cs1_n_o,
  output logic      cs2_o,
  output logic      oe_n_o,
  output logic      we_n_o,
  output logic      dq_oe_o,
  output logic      rdy_o
);

  logic sel_d;
  assign sel_d = (state_d_i == ST_RD)   || (state_d_i == ST_WSET) ||
                 (state_d_i == ST_WPUL) || (state_d_i == ST_WHLD);

  // strobes come straight from flops: no decode glitches reach the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs1_n_o <= 1'b1;
      cs2_o   <= 1'b0;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
      rdy_o   <= 1'b0;
    end else begin
      cs1_n_o <= !sel_d;
      cs2_o   <= sel_d;
      oe_n_o  <= (state_d_i != ST_RD);
      we_n_o  <= (state_d_i != ST_WPUL);
      dq_oe_o <= (state_d_i == ST_WPUL) || (state_d_i == ST_WHLD);
      rdy_o   <= (state_d_i == ST_DONE);
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RD_CYCLES  = 3,
  parameter int unsigned OE_WAIT    = 2,
  parameter int unsigned WE_PULSE   = 2,
  parameter int unsigned DATA_SETUP = 3,
  parameter int unsigned WR_CYCLES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs1_n_o,
  output logic              mem_cs2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned N_RD  = max2(RD_CYCLES, OE_WAIT);
  localparam int unsigned N_WR  = (WR_CYCLES > 2) ? WR_CYCLES - 2 : 1;
  localparam int unsigned N_WP  = max2(max2(WE_PULSE, DATA_SETUP), N_WR);
  localparam int unsigned CNT_W = $clog2(max2(N_RD, N_WP) + 1);

  logic             load, zero, accept, capture;
  logic [CNT_W-1:0] len;
  asram_st_e        state_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  asram_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .zero_o (zero)
  );

  asram_seq #(.N_RD(N_RD), .N_WP(N_WP), .CNT_W(CNT_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wr_i      (wr_i),
    .zero_i    (zero),
    .load_o    (load),
    .len_o     (len),
    .accept_o  (accept),
    .capture_o (capture),
    .state_d_o (state_d)
  );

  asram_pins i_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .cs1_n_o   (mem_cs1_n_o),
    .cs2_o     (mem_cs2_o),
    .oe_n_o    (mem_oe_n_o),
    .we_n_o    (mem_we_n_o),
    .dq_oe_o   (mem_dq_oe_o),
    .rdy_o     (rdy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_i;
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned WE_PULSE   = 2,
  parameter int unsigned DATA_SETUP = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rdy_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs1_n_o,
  input logic              mem_cs2_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o
);

  logic [15:0] we_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_lo_cnt <= '0;
    else if (!mem_we_n_o) we_lo_cnt <= we_lo_cnt + 16'd1;
    else                  we_lo_cnt <= '0;
  end

  // R1
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (mem_cs1_n_o && !mem_cs2_o && mem_oe_n_o && mem_we_n_o));

  // R5
  we_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt >= WE_PULSE) && (we_lo_cnt >= DATA_SETUP));

  // R6
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  // R6
  oe_high_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o);

  // R6
  drive_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_n_o || $past(!mem_we_n_o)));

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs1_n_o && $past(!mem_cs1_n_o)) |-> $stable(mem_addr_o));

  // R8
  rdy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);

  // R9
  cs_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs1_n_o != mem_cs2_o);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .WE_PULSE   (WE_PULSE),
  .DATA_SETUP (DATA_SETUP)
) i_asram_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rdy_o       (rdy_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cs1_n_o (mem_cs1_n_o),
  .mem_cs2_o   (mem_cs2_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RD_CYCLES  = 3;
  localparam int OE_WAIT    = 2;
  localparam int WE_PULSE   = 2;
  localparam int DATA_SETUP = 3;
  localparam int WR_CYCLES  = 4;
  // expected sequence lengths, from R3 and R5
  localparam int N_RD   = (RD_CYCLES > OE_WAIT) ? RD_CYCLES : OE_WAIT;
  localparam int N_WP0  = (WE_PULSE > DATA_SETUP) ? WE_PULSE : DATA_SETUP;
  localparam int N_WP   = (N_WP0 > WR_CYCLES - 2) ? N_WP0 : WR_CYCLES - 2;
  localparam int LAT_RD = N_RD + 1;
  localparam int LAT_WR = N_WP + 3;
  localparam logic [12:0] POKE_A = 13'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rdy;
  logic [7:0]  rdata;
  logic [12:0] m_addr;
  logic        m_cs1_n, m_cs2, m_oe_n, m_we_n, m_dq_oe;
  logic [7:0]  m_dq_o;
  logic [7:0]  m_dq_i = '0;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem_model [int];
  logic [7:0] exp_mem   [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(
    .RD_CYCLES(RD_CYCLES), .OE_WAIT(OE_WAIT), .WE_PULSE(WE_PULSE),
    .DATA_SETUP(DATA_SETUP), .WR_CYCLES(WR_CYCLES)
  ) i_asram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdy_o(rdy), .rdata_o(rdata), .mem_addr_o(m_addr),
    .mem_cs1_n_o(m_cs1_n), .mem_cs2_o(m_cs2), .mem_oe_n_o(m_oe_n),
    .mem_we_n_o(m_we_n), .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe),
    .mem_dq_i(m_dq_i)
  );

  function automatic logic [7:0] init_val(logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] exp_val(logic [12:0] a);
    return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : init_val(a);
  endfunction

  function automatic logic [7:0] model_rd(logic [12:0] a);
    return mem_model.exists(int'(a)) ? mem_model[int'(a)] : init_val(a);
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, expv);
    end
  endtask

  // memory model: timing-sensitive, corrupts data on short timing (R4, R5, R6, R9)
  int   sel_cnt = 0, a_cnt = 0, oe_cnt = 0, we_cnt = 0, d_cnt = 0;
  int   viol = 0;
  logic [12:0] last_a = '0;
  logic [7:0]  last_d = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic sel, ok;
      logic [7:0] v;
      sel = !m_cs1_n && m_cs2;
      if (m_cs1_n == m_cs2) begin viol++; $display("FAIL R9 cs1_n=%0b cs2=%0b expected opposite", m_cs1_n, m_cs2); end
      if (m_dq_oe && !m_oe_n) begin viol++; $display("FAIL R6 dq_oe=1 oe_n=0 expected oe_n=1"); end
      if (!m_we_n && !m_oe_n) begin viol++; $display("FAIL R6 we_n=0 oe_n=0 expected oe_n=1"); end
      if (sel) begin
        a_cnt = (sel_cnt == 0 || m_addr == last_a) ? a_cnt + 1 : 1;
        sel_cnt++;
      end else begin
        sel_cnt = 0;
        a_cnt   = 0;
      end
      last_a = m_addr;
      oe_cnt = (sel && !m_oe_n && m_we_n) ? oe_cnt + 1 : 0;
      if (sel && !m_we_n) begin
        d_cnt = (m_dq_oe && (we_cnt == 0 || m_dq_o == last_d)) ? d_cnt + 1 : 0;
        we_cnt++;
      end else if (we_cnt != 0) begin
        ok = sel && m_dq_oe && (we_cnt >= WE_PULSE) && (d_cnt >= DATA_SETUP) &&
             (m_dq_o == last_d) && (sel_cnt >= WR_CYCLES);
        mem_model[int'(m_addr)] = ok ? m_dq_o : ~m_dq_o;
        we_cnt = 0;
        d_cnt  = 0;
      end
      last_d = m_dq_o;
      v = model_rd(m_addr);
      m_dq_i <= (oe_cnt >= OE_WAIT && a_cnt >= RD_CYCLES) ? v : ~v;
    end
  end

  task automatic access(input bit w, input logic [12:0] a, input logic [7:0] d,
                        input bit poke, output logic [7:0] rd);
    int  lat;
    bit  seen;
    seen = 0;
    rd   = '0;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    // scramble client inputs after acceptance (R7)
    req = 1'b0; wr = ~w; addr = ~a; wdata = ~d;
    lat = 1;
    while (!seen && lat < 64) begin
      if (rdy) begin
        seen = 1;
        rd   = rdata;
      end else begin
        if (poke && lat == 2) begin
          req = 1'b1; wr = 1'b1; addr = POKE_A; wdata = 8'h5A;  // R2: busy request
        end else begin
          req = 1'b0;
        end
        @(negedge clk);
        lat++;
      end
    end
    req = 1'b0;
    if (w) chk("R5 write ready latency", lat, LAT_WR);
    else   chk("R3 read ready latency", lat, LAT_RD);
    @(negedge clk);
    chk("R8 ready single clock", rdy, 1'b0);
    if (w) exp_mem[int'(a)] = d;
  endtask

  initial begin
    repeat (1000 * 150) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 cs1_n in reset", m_cs1_n, 1'b1);
    chk("R1 cs2 in reset", m_cs2, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle strobes", {m_cs1_n, m_cs2, m_oe_n, m_we_n, m_dq_oe, rdy}, 6'b101100);

    // directed corners
    access(1'b1, 13'h0000, 8'h00, 1'b0, rd);
    access(1'b1, 13'h1FFF, 8'hFF, 1'b0, rd);
    access(1'b0, 13'h0000, 8'h00, 1'b0, rd);
    chk("R3 read first address", rd, exp_val(13'h0000));
    access(1'b0, 13'h1FFF, 8'h00, 1'b0, rd);
    chk("R4 read last address", rd, exp_val(13'h1FFF));
    access(1'b1, 13'h0AAA, 8'hC3, 1'b0, rd);
    access(1'b0, 13'h0AAA, 8'h00, 1'b0, rd);
    chk("R5 store then load same byte", rd, 8'hC3);
    access(1'b0, 13'h0555, 8'h00, 1'b0, rd);
    chk("R4 read unwritten byte", rd, init_val(13'h0555));

    // R2: busy-time request must be ignored
    access(1'b0, 13'h0010, 8'h00, 1'b1, rd);
    chk("R2 read during poke", rd, exp_val(13'h0010));
    access(1'b1, 13'h0011, 8'h77, 1'b1, rd);
    access(1'b0, POKE_A, 8'h00, 1'b0, rd);
    chk("R2 poked address untouched", rd, exp_val(POKE_A));
    chk("R6 drive off when idle", m_dq_oe, 1'b0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [12:0] a;
      logic [7:0]  d;
      bit          w;
      int          sel;
      sel = $urandom_range(0, 3);
      if (sel == 0)      a = 13'($urandom_range(0, 15));
      else if (sel == 1) a = 13'($urandom_range(8176, 8191));
      else if (sel == 2) a = 13'($urandom_range(100, 131));
      else               a = 13'($urandom);
      if (a == POKE_A) a = a ^ 13'h1;
      d = 8'($urandom);
      w = $urandom_range(0, 1) == 1;
      access(w, a, d, (i % 37) == 5, rd);
      if (!w) chk("R7 random read-back", rd, exp_val(a));
    end

    chk("R9 R6 protocol violations", viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule